// File: doc/BRIEF.md
# Three-Channel Resistor Setting Register with Two-Wire Slave Port

This block is a two-wire serial slave that stores three 8-bit setting words, one for each channel of a variable resistor array. SCL and SDA arrive as raw pin levels. The block resynchronises them to the system clock and finds the bus events: start, repeated start and stop. It drives SDA only through an open-drain pull-low enable.

The first byte after any start is the command byte. If it names this device, the slave acknowledges it. A write then supplies a register-address byte followed by data bytes. A read returns the register that the last register-address byte selected.

Each stored word feeds two outputs of its channel. Bit 7 is a flag that floats the channel. Bits 6:0 are the 128-step wiper position.

Top module: `tri_wiper_i2c_slave`

## Requirements
- R1: After reset all three setting words are 00h and SDA is released (`sda_pull` low).
- R2: The slave answers a command byte only when its bits 7:2 equal the `FAMILY` parameter (default 101000b) and its bit 1 equals `sel_pin`. It answers by pulling SDA low during the ninth clock. Bit 0 of the command byte selects the direction: 1 is a read, 0 is a write.
- R3: A command byte that does not match gets no acknowledge. All later bytes up to the next start or stop are ignored, and the setting words stay unchanged.
- R4: In a write, the slave acknowledges the register-address byte and every data byte.
- R5: Register address F8h selects channel 0, F9h selects channel 1 and FAh selects channel 2. Each data byte of a write replaces the selected word on its acknowledge cycle.
- R6: Each word drives two outputs of its channel. Bit 7 drives `chN_hiz` and bits 6:0 drive `chN_pos`.
- R7: A read uses a write command and a register address, then a repeated start and the command with bit 0 set. The slave then sends the selected word MSB first. If the master acknowledges, the same word is sent again. After a NACK, SDA stays released.
- R8: A register address outside F8h..FAh is still acknowledged. Data written to it is dropped, and a read from it returns 00h.
- R9: A start that arrives in the middle of a byte abandons that byte, and address recognition begins again at once.
- R10: The SDA drive changes only while the synchronised SCL is low.
- R11: SDA is released on the cycle after a detected start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which also samples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | SCL pin level |
| sda_in | input | 1 | SDA pin level (the wired-AND bus) |
| sel_pin | input | 1 | Device select level, compared with bit 1 of the command byte |
| sda_pull | output | 1 | 1 pulls SDA low; 0 releases it |
| ch0_hiz | output | 1 | Channel 0 float flag |
| ch0_pos | output | 7 | Channel 0 wiper position |
| ch1_hiz | output | 1 | Channel 1 float flag |
| ch1_pos | output | 7 | Channel 1 wiper position |
| ch2_hiz | output | 1 | Channel 2 float flag |
| ch2_pos | output | 7 | Channel 2 wiper position |

## Verification
The hardest case to reach is a start that cuts a data byte short after only a few of its bits have been shifted in. The bench drives single bits by hand to do this. It then raises SDA while SCL is low and issues a start, before a full byte boundary is reached. It confirms that the new command byte is acknowledged, that the word addressed before the start is untouched, and that the new write lands. Mismatched commands are checked against a word whose value was set earlier in the run, so a write that should have been dropped would show up as a change.

// File: rtl/tri_wiper_i2c_slave.sv
module tri_wiper_i2c_slave #(
  parameter logic [5:0] FAMILY   = 6'b101000,
  parameter logic [7:0] REG_BASE = 8'hF8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       sel_pin,
  output logic       sda_pull,
  output logic       ch0_hiz,
  output logic [6:0] ch0_pos,
  output logic       ch1_hiz,
  output logic [6:0] ch1_pos,
  output logic       ch2_hiz,
  output logic [6:0] ch2_pos
);
  localparam int NCH = 3;

  typedef enum logic [3:0] {
    IDLE, CMD, CMD_ACK, PTR, PTR_ACK, WR, WR_ACK, RD, RD_ACK
  } st_t;

  st_t        state;
  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  logic [3:0] cnt;
  logic [7:0] sr, ptr, tx, rd_val;
  logic       rw, mack;
  logic [7:0] regs [NCH];

  wire scl_s = scl_sy[1];
  wire sda_s = sda_sy[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  wire start_ev  = scl_q & scl_s & sda_q & ~sda_s;
  wire stop_ev   = scl_q & scl_s & ~sda_q & sda_s;
  wire rise      = ~scl_q & scl_s;
  wire fall      = scl_q & ~scl_s;
  wire byte_done = (cnt == 4'd8);
  wire cmd_hit   = (sr[7:2] == FAMILY) && (sr[1] == sel_pin);

  wire [7:0] ofs    = ptr - REG_BASE;
  wire       ptr_ok = (ofs < 8'(NCH));

  always_comb rd_val = ptr_ok ? regs[ofs[1:0]] : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= IDLE;
      cnt      <= '0;
      sr       <= '0;
      ptr      <= '0;
      tx       <= '0;
      rw       <= 1'b0;
      mack     <= 1'b1;
      sda_pull <= 1'b0;
      for (int i = 0; i < NCH; i++) regs[i] <= '0;
    end else if (start_ev) begin
      state    <= CMD;
      cnt      <= '0;
      sda_pull <= 1'b0;
    end else if (stop_ev) begin
      state    <= IDLE;
      sda_pull <= 1'b0;
    end else begin
      case (state)
        CMD, PTR, WR: begin
          if (rise && !byte_done) begin
            sr  <= {sr[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (fall && byte_done) begin
            cnt <= '0;
            if (state == CMD) begin
              if (cmd_hit) begin
                rw       <= sr[0];
                sda_pull <= 1'b1;
                state    <= CMD_ACK;
              end else begin
                state <= IDLE;
              end
            end else if (state == PTR) begin
              ptr      <= sr;
              sda_pull <= 1'b1;
              state    <= PTR_ACK;
            end else begin
              if (ptr_ok) regs[ofs[1:0]] <= sr;
              sda_pull <= 1'b1;
              state    <= WR_ACK;
            end
          end
        end
        CMD_ACK: if (fall) begin
          if (rw) begin
            tx       <= rd_val;
            sda_pull <= ~rd_val[7];
            cnt      <= '0;
            state    <= RD;
          end else begin
            sda_pull <= 1'b0;
            state    <= PTR;
          end
        end
        PTR_ACK, WR_ACK: if (fall) begin
          sda_pull <= 1'b0;
          state    <= WR;
        end
        RD: begin
          if (rise) begin
            cnt <= cnt + 4'd1;
          end else if (fall) begin
            if (byte_done) begin
              sda_pull <= 1'b0;
              cnt      <= '0;
              state    <= RD_ACK;
            end else begin
              tx       <= {tx[6:0], 1'b0};
              sda_pull <= ~tx[6];
            end
          end
        end
        RD_ACK: begin
          if (rise) begin
            mack <= sda_s;
          end else if (fall) begin
            if (!mack) begin
              tx       <= rd_val;
              sda_pull <= ~rd_val[7];
              cnt      <= '0;
              state    <= RD;
            end else begin
              state <= IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign ch0_hiz = regs[0][7];
  assign ch0_pos = regs[0][6:0];
  assign ch1_hiz = regs[1][7];
  assign ch1_pos = regs[1][6:0];
  assign ch2_hiz = regs[2][7];
  assign ch2_pos = regs[2][6:0];
endmodule

// File: rtl/tri_wiper_chk.sv
module tri_wiper_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_s,
  input logic       sda_pull,
  input logic [7:0] w0,
  input logic [7:0] w1,
  input logic [7:0] w2
);
  // R10
  sda_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !$past(scl_s));

  // R11
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && $fell(sda_s)) |=> !sda_pull);

  // R11
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && $rose(sda_s)) |=> !sda_pull);

  // R5
  word_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({w0, w1, w2}) |-> sda_pull);
endmodule

bind tri_wiper_i2c_slave tri_wiper_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s), .sda_pull(sda_pull),
  .w0({ch0_hiz, ch0_pos}), .w1({ch1_hiz, ch1_pos}), .w2({ch2_hiz, ch2_pos})
);

// File: tb/tri_wiper_i2c_slave_bench.sv
module tri_wiper_i2c_slave_bench;
  localparam int Q = 10;
  localparam int NV = 6;
  // {sel_pin, register address, data, expected read-back}
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 8'hF8, 8'h55, 8'h55},
    {1'b1, 8'hF9, 8'h80, 8'h80},
    {1'b0, 8'hFA, 8'h7F, 8'h7F},
    {1'b1, 8'hF8, 8'hFF, 8'hFF},
    {1'b0, 8'hFB, 8'h3C, 8'h00},
    {1'b0, 8'hF7, 8'h12, 8'h00}
  };

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, sel_pin = 1'b0;
  logic sda_pull, ch0_hiz, ch1_hiz, ch2_hiz;
  logic [6:0] ch0_pos, ch1_pos, ch2_pos;
  wire sda_bus = sda_m & ~sda_pull;
  int n_chk = 0, n_bad = 0;
  logic [7:0] model [3];

  always #5 clk = ~clk;

  tri_wiper_i2c_slave u_tri_wiper_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus), .sel_pin(sel_pin),
    .sda_pull(sda_pull), .ch0_hiz(ch0_hiz), .ch0_pos(ch0_pos),
    .ch1_hiz(ch1_hiz), .ch1_pos(ch1_pos), .ch2_hiz(ch2_hiz), .ch2_pos(ch2_pos)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(int n = Q); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; hold(); scl_m = 1'b1; hold(); sda_m = 1'b0; hold(); scl_m = 1'b0; hold();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(); scl_m = 1'b1; hold(); sda_m = 1'b1; hold();
  endtask

  task automatic send_bit(logic b);
    sda_m = b; hold(); scl_m = 1'b1; hold(); scl_m = 1'b0; hold();
  endtask

  task automatic send_byte(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; hold(); scl_m = 1'b1; hold(Q/2);
    ack = ~sda_bus; hold(Q/2); scl_m = 1'b0; hold();
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic give_ack);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      sda_m = 1'b1; hold(); scl_m = 1'b1; hold(Q/2);
      b = {b[6:0], sda_bus}; hold(Q/2); scl_m = 1'b0; hold();
    end
    send_bit(~give_ack);
  endtask

  task automatic check_words(string req);
    check({req, " ch0"}, {ch0_hiz, ch0_pos}, model[0]);
    check({req, " ch1"}, {ch1_hiz, ch1_pos}, model[1]);
    check({req, " ch2"}, {ch2_hiz, ch2_pos}, model[2]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] d, cw;
    for (int i = 0; i < 3; i++) model[i] = 8'h00;
    hold(5);
    rst_n = 1'b1;
    hold(5);
    // R1 reset state
    check_words("R1");
    check("R1 sda released", sda_pull, 1'b0);

    for (int v = 0; v < NV; v++) begin
      logic [7:0] ra, dat, exp;
      sel_pin = VEC[v][24];
      ra = VEC[v][23:16]; dat = VEC[v][15:8]; exp = VEC[v][7:0];
      cw = {6'b101000, sel_pin, 1'b0};
      bus_start();
      send_byte(cw, a);  check("R2 command ack", a, 1'b1);
      send_byte(ra, a);  check(ra inside {[8'hF8:8'hFA]} ? "R4 address ack" : "R8 address ack", a, 1'b1);
      send_byte(dat, a); check("R4 data ack", a, 1'b1);
      bus_stop();
      if (ra >= 8'hF8 && ra <= 8'hFA) model[ra - 8'hF8] = dat;
      check_words(ra inside {[8'hF8:8'hFA]} ? "R5" : "R8");
      bus_start();
      send_byte(cw, a);
      send_byte(ra, a);
      bus_start();
      send_byte(cw | 8'h01, a); check("R7 read command ack", a, 1'b1);
      recv_byte(d, 1'b0);
      check(ra inside {[8'hF8:8'hFA]} ? "R7 read data" : "R8 read data", d, exp);
      check("R7 released after nack", sda_pull, 1'b0);
      bus_stop();
    end

    // R6 field split: F9 holds 80h, FA holds 7Fh
    check("R6 ch1 hiz", ch1_hiz, 1'b1);
    check("R6 ch1 pos", ch1_pos, 7'h00);
    check("R6 ch2 hiz", ch2_hiz, 1'b0);
    check("R6 ch2 pos", ch2_pos, 7'h7F);

    // R3 wrong select bit
    sel_pin = 1'b1;
    bus_start();
    send_byte(8'hA0, a); check("R3 select mismatch nack", a, 1'b0);
    send_byte(8'hF8, a); check("R3 ignored address byte", a, 1'b0);
    send_byte(8'h11, a); check("R3 ignored data byte", a, 1'b0);
    bus_stop();
    check_words("R3");
    // R3 wrong family code
    bus_start();
    send_byte(8'hB2, a); check("R3 family mismatch nack", a, 1'b0);
    send_byte(8'hF8, a);
    send_byte(8'h22, a);
    bus_stop();
    check_words("R3");

    // R9 start inside a data byte
    sel_pin = 1'b0;
    bus_start();
    send_byte(8'hA0, a);
    send_byte(8'hF8, a);
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
    bus_start();
    send_byte(8'hA0, a); check("R9 command ack after restart", a, 1'b1);
    send_byte(8'hF9, a);
    send_byte(8'h2A, a);
    bus_stop();
    model[1] = 8'h2A;
    check_words("R9");

    // R7 master ack repeats the same word
    bus_start();
    send_byte(8'hA0, a);
    send_byte(8'hF9, a);
    bus_start();
    send_byte(8'hA1, a);
    recv_byte(d, 1'b1); check("R7 first byte", d, 8'h2A);
    recv_byte(d, 1'b0); check("R7 repeated byte", d, 8'h2A);
    check("R7 released after nack", sda_pull, 1'b0);
    bus_stop();
    check("R11 released after stop", sda_pull, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule